// File: doc/BRIEF.md
# Bang-Bang Clock Recovery Loop Controller

This block is the digital half of a half-rate bang-bang clock recovery loop. On every half-rate clock it receives two data decisions and two crossing (edge) decisions from the samplers. From these it forms one early/late vote per half. The votes go to two paths. The proportional path turns their net sign into a one-cycle up/down pulse that steers the oscillator directly. The integral path adds the same net value, scaled by a programmable shift, into a wide saturating counter. The upper bits of that counter form the current-DAC fine-tune code.

Before the loop closes, a startup sequencer owns the same DAC code. It counts divided-oscillator pulses over fixed windows of reference cycles and compares each count with a programmed target. It settles the code one bit at a time, from the MSB down. When the last bit is decided, it seeds the integrator with the result, raises a ready flag and hands the code over to the loop.

Top module: `cdr_bb_loop`

## Requirements
- R1: During and right after reset, `dac_code` is midscale (128, only the MSB set), `lock_ready` is 0, and `prop_up` and `prop_dn` are 0.
- R2: Calibration settles bits from MSB to LSB. A trial bit is kept when the number of `osc_div_pulse` pulses counted in its window is below `cal_target`, and cleared otherwise. The final code is therefore the largest code whose window count is below the target; it is 0 when no code qualifies.
- R3: Calibration uses 8 windows of 64 clocks. `lock_ready` rises exactly 512 clocks after reset release and stays high until the next reset.
- R4: While `lock_ready` is 0, `prop_up` and `prop_dn` stay 0 and the sampler inputs have no effect on the calibration result.
- R5: Half A compares the previous cycle's `d_b` with `d_a` and `e_a`. Half B compares `d_a` with `d_b` and `e_b`. A half with no data change votes 0. If there is a change, the half votes +1 (late) when the edge equals the new bit and -1 (early) when it equals the old bit. The net value is the sum of the two votes.
- R6: After lock, one clock after the samples are presented, `prop_up` is 1 exactly when the net is positive and `prop_dn` is 1 exactly when it is negative. The two are never high together.
- R7: At lock, the 20-bit integrator holds the calibrated code in its top 8 bits with zeros below. Each locked clock adds net × 2^`gain_sh`, and `dac_code` is the integrator's top 8 bits.
- R8: The integrator saturates at 0 and at its full-scale value and never wraps.
- R9: After lock, `osc_div_pulse` has no effect: with a zero net vote, `dac_code` holds while pulses continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate / reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_target | input | 7 | Target pulse count per calibration window |
| osc_div_pulse | input | 1 | Divided oscillator pulse, one clock wide, already synchronized |
| gain_sh | input | 4 | Integral gain as a left shift of the net vote |
| d_a | input | 1 | Data decision, first half |
| e_a | input | 1 | Edge decision preceding `d_a` |
| d_b | input | 1 | Data decision, second half |
| e_b | input | 1 | Edge decision between `d_a` and `d_b` |
| prop_up | output | 1 | Proportional speed-up pulse |
| prop_dn | output | 1 | Proportional slow-down pulse |
| dac_code | output | 8 | Oscillator fine-tune DAC code |
| lock_ready | output | 1 | Calibration finished, loop owns the DAC code |

## Verification
The hardest states to reach are the integrator's two rails. They exist only after a calibration that ended at code 0 or code 255, and only under a sustained one-sided vote. The bench models the oscillator as pulse counts that follow the current DAC code, with a window count of code/4. With targets of 0 and 64 the search ends at either extreme. The bench then drives repeated early or late patterns at maximum gain and checks that the first opposite vote steps the code back by one.

// File: rtl/cdr_bb_loop.sv
module cdr_bb_loop #(
  parameter int DAC_W   = 8,
  parameter int ACC_W   = 20,
  parameter int SH_W    = 4,
  parameter int WIN_LEN = 64,
  parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cal_target,
  input  logic             osc_div_pulse,
  input  logic [SH_W-1:0]  gain_sh,
  input  logic             d_a,
  input  logic             e_a,
  input  logic             d_b,
  input  logic             e_b,
  output logic             prop_up,
  output logic             prop_dn,
  output logic [DAC_W-1:0] dac_code,
  output logic             lock_ready
);
  localparam int FRAC_W = ACC_W - DAC_W;
  localparam int IDX_W  = $clog2(DAC_W);
  localparam int WC_W   = $clog2(WIN_LEN);

  function automatic logic signed [1:0] half_vote(input logic prv, input logic cur, input logic edg);
    if (prv == cur) return 2'sd0;
    return (edg == cur) ? 2'sd1 : -2'sd1;
  endfunction

  logic               prev_b;
  logic signed [1:0]  v_a, v_b;
  logic signed [2:0]  net;
  assign v_a = half_vote(prev_b, d_a, e_a);
  assign v_b = half_vote(d_a, d_b, e_b);
  assign net = {v_a[1], v_a} + {v_b[1], v_b};

  logic [ACC_W-1:0]          acc, acc_nxt;
  logic signed [ACC_W+1:0]   step, sum;
  localparam logic signed [ACC_W+1:0] ACC_MAX = {2'b00, {ACC_W{1'b1}}};
  assign step = $signed({{(ACC_W-1){net[2]}}, net}) <<< gain_sh;
  assign sum  = $signed({2'b00, acc}) + step;
  always_comb begin
    if (sum < 0)            acc_nxt = '0;
    else if (sum > ACC_MAX) acc_nxt = '1;
    else                    acc_nxt = sum[ACC_W-1:0];
  end

  logic [WC_W-1:0]  wcnt;
  logic [CNT_W-1:0] pcnt, cnt_tot;
  logic [DAC_W-1:0] trial, decided, bitm;
  logic [IDX_W-1:0] idx;
  logic             win_end;
  assign win_end = (wcnt == WC_W'(WIN_LEN - 1));
  assign cnt_tot = pcnt + CNT_W'(osc_div_pulse);
  assign bitm    = DAC_W'(1) << idx;
  assign decided = (cnt_tot < cal_target) ? trial : (trial & ~bitm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_b     <= 1'b0;
      wcnt       <= '0;
      pcnt       <= '0;
      trial      <= {1'b1, {(DAC_W-1){1'b0}}};
      idx        <= IDX_W'(DAC_W - 1);
      acc        <= '0;
      lock_ready <= 1'b0;
      prop_up    <= 1'b0;
      prop_dn    <= 1'b0;
    end else begin
      prev_b <= d_b;
      if (!lock_ready) begin
        wcnt <= win_end ? '0 : wcnt + WC_W'(1);
        pcnt <= win_end ? '0 : cnt_tot;
        if (win_end) begin
          if (idx == '0) begin
            lock_ready <= 1'b1;
            acc        <= {decided, {FRAC_W{1'b0}}};
          end else begin
            trial <= decided | (bitm >> 1);
            idx   <= idx - IDX_W'(1);
          end
        end
      end else begin
        acc     <= acc_nxt;
        prop_up <= (net > 3'sd0);
        prop_dn <= (net < 3'sd0);
      end
    end
  end

  assign dac_code = lock_ready ? acc[ACC_W-1 -: DAC_W] : trial;
endmodule

// File: rtl/cdr_bb_loop_chk.sv
module cdr_bb_loop_chk #(
  parameter int DAC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prop_up,
  input logic             prop_dn,
  input logic             lock_ready,
  input logic [DAC_W-1:0] dac_code
);
  AST_PROP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(prop_up && prop_dn)); // R6
  AST_PROP_QUIET_CAL: assert property (@(posedge clk) disable iff (!rst_n) !lock_ready |-> (!prop_up && !prop_dn)); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) lock_ready |=> lock_ready); // R3
  AST_UP_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_ready && $past(lock_ready) && prop_up) |-> (dac_code >= $past(dac_code))); // R8
  AST_DN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_ready && $past(lock_ready) && prop_dn) |-> (dac_code <= $past(dac_code))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_ready && $past(lock_ready) && !prop_up && !prop_dn) |-> $stable(dac_code)); // R9
endmodule

bind cdr_bb_loop cdr_bb_loop_chk #(.DAC_W(DAC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .prop_up(prop_up), .prop_dn(prop_dn),
  .lock_ready(lock_ready), .dac_code(dac_code)
);

// File: tb/cdr_bb_loop_tb_top.sv
`timescale 1ns/1ps
module cdr_bb_loop_tb_top;
  logic clk = 0, rst_n = 0;
  logic [6:0] cal_target = 0;
  logic osc_div_pulse = 0;
  logic [3:0] gain_sh = 0;
  logic d_a = 0, e_a = 0, d_b = 0, e_b = 0;
  logic prop_up, prop_dn, lock_ready;
  logic [7:0] dac_code;
  int total = 0, bad = 0, wpos = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cdr_bb_loop dut_i (.clk(clk), .rst_n(rst_n), .cal_target(cal_target), .osc_div_pulse(osc_div_pulse),
    .gain_sh(gain_sh), .d_a(d_a), .e_a(e_a), .d_b(d_b), .e_b(e_b),
    .prop_up(prop_up), .prop_dn(prop_dn), .dac_code(dac_code), .lock_ready(lock_ready));

  // oscillator model: window count equals code/4
  always @(posedge clk) begin
    #1;
    if (!rst_n) wpos = 0; else wpos = wpos + 1;
    osc_div_pulse = ((wpos % 64) < (dac_code >> 2));
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic drive(input logic da, input logic ea, input logic db, input logic eb);
    d_a = da; e_a = ea; d_b = db; e_b = eb;
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic reset_to(input int tgt);
    @(negedge clk); rst_n = 0; cal_target = 7'(tgt); drive(0,0,0,0);
    step(3);
    rst_n = 1;
  endtask

  function automatic int exp_code(input int tgt);
    int c = 4 * tgt - 1;
    if (c < 0) c = 0;
    if (c > 255) c = 255;
    return c;
  endfunction

  task automatic cal_run(input int tgt);
    reset_to(tgt);
    step(511);
    chk(lock_ready == 0, "R3 ready before 512", lock_ready, 0);
    step(1);
    chk(lock_ready == 1, "R3 ready at 512", lock_ready, 1);
    chk(dac_code == exp_code(tgt), "R2 final code", dac_code, exp_code(tgt));
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 0; step(2);
    chk(dac_code == 128, "R1 reset code", dac_code, 128);
    chk(lock_ready == 0, "R1 reset ready", lock_ready, 0);
    chk(!prop_up && !prop_dn, "R1 reset prop", {prop_up, prop_dn}, 0);
  endtask

  task automatic t_cal_targets();
    cal_run(20);
    cal_run(1);
    step(100);
    chk(lock_ready == 1, "R3 ready sticky", lock_ready, 1);
  endtask

  task automatic t_cal_noise();
    reset_to(20);
    drive(1,1,0,0);
    step(200);
    chk(!prop_up && !prop_dn, "R4 prop quiet in cal", {prop_up, prop_dn}, 0);
    step(311);
    chk(lock_ready == 0, "R4 still calibrating", lock_ready, 0);
    drive(0,0,0,0);
    step(1);
    chk(dac_code == 79, "R4 votes ignored in cal", dac_code, 79);
  endtask

  task automatic t_votes();
    cal_run(20);
    gain_sh = 11;
    drive(1,1,0,0); step(1);
    chk(prop_up && !prop_dn, "R6 late gives up", {prop_up, prop_dn}, 2);
    chk(dac_code == 80, "R7 late step", dac_code, 80);
    step(3);
    chk(dac_code == 83, "R7 late run", dac_code, 83);
    drive(1,0,0,1); step(1);
    chk(!prop_up && prop_dn, "R6 early gives dn", {prop_up, prop_dn}, 1);
    chk(dac_code == 82, "R5 early net -2", dac_code, 82);
    drive(1,1,0,1); step(3);
    chk(!prop_up && !prop_dn, "R5 mixed net 0", {prop_up, prop_dn}, 0);
    chk(dac_code == 82, "R9 hold with pulses", dac_code, 82);
    drive(0,1,0,1); step(2);
    chk(!prop_up && !prop_dn && dac_code == 82, "R5 no transitions", dac_code, 82);
    drive(1,1,1,0); step(1);
    chk(prop_up && dac_code == 82, "R5 single half +1", dac_code, 82);
    drive(1,1,0,0); step(1);
    chk(prop_up && dac_code == 83, "R5 half B only +1", dac_code, 83);
    gain_sh = 0; step(10);
    chk(dac_code == 83, "R7 gain 0 small", dac_code, 83);
    gain_sh = 10; step(4);
    chk(dac_code == 85, "R7 gain 10", dac_code, 85);
  endtask

  task automatic t_sat();
    cal_run(64);
    gain_sh = 11;
    drive(1,1,0,0); step(5);
    chk(dac_code == 255, "R8 top rail", dac_code, 255);
    drive(1,0,0,1); step(1);
    chk(dac_code == 254, "R8 top no wrap", dac_code, 254);
    cal_run(0);
    drive(1,0,0,1); step(5);
    chk(dac_code == 0, "R8 bottom rail", dac_code, 0);
    drive(1,1,0,0); step(1);
    chk(dac_code == 1, "R8 bottom no wrap", dac_code, 1);
  endtask

  initial begin
    t_reset();
    t_cal_targets();
    t_cal_noise();
    t_votes();
    t_sat();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule